// File: doc/BRIEF.md
# Two-Wire Controller Command Register

This block is the software-facing command and status register of a two-wire serial (I2C-style) controller. A CPU writes and reads one 8-bit control word through a small write port. The block turns that word into plain level and pulse commands for a separate bit-level bus engine: hold the clock low, request a start or a stop, acknowledge received bytes, return to the unaddressed slave state, run the engine and raise an interrupt. The engine reports back with one-cycle event pulses, and these update the same word.

The completion flag sits at the centre of the handshake. The engine sets it when it finishes an operation. The flag keeps the clock stretched and can raise an interrupt. Software clears it by writing a one to it, and that clear sends the engine a one-cycle launch pulse for the next operation. A stop command has two meanings. In master mode it asks for a stop condition on the bus. In slave mode it only resets the engine to the idle, unaddressed state.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `twc_ctrl_reg`

## Requirements
- R1: `cpu_rdata` always shows the control word. Bit 7 is the completion flag, bit 6 ACK enable, bit 5 start request, bit 4 stop request, bit 3 collision flag, bit 2 interface enable, bit 1 reads 0, bit 0 interrupt enable. A control write (`cpu_wr`=1, `cpu_sel_data`=0) loads bits 6, 5, 4, 2 and 0 from `cpu_wdata`, and the new value reads back from the next cycle. Bits 3 and 1 ignore control writes.
- R2: `scl_hold` is 1 exactly when the completion flag and the interface enable are both 1.
- R3: A control write with bit 7 = 1 clears a set completion flag. `eng_go` is then 1 for exactly the one cycle in which the flag first reads 0. A write with bit 7 = 0 leaves the flag unchanged, and the flag never clears by itself.
- R4: An `eng_done` pulse while enabled sets the completion flag for the next cycle. If it coincides with a clearing write, the flag stays 1 and no `eng_go` pulse is produced.
- R5: `ack_level` equals ACK enable ANDed with the interface enable. `ack_pulse` is 1 when `ack_level` is 1 and at least one of these holds: `eng_own_addr`; `eng_gen_call` together with `gcall_recog`; `eng_byte_rx`.
- R6: When the start bit and the enable are 1 and the bus is free, `start_req` rises one cycle after the start bit first reads 1. If the bus is busy, it rises one cycle after an `eng_stop_seen` pulse. `start_req` drops after `eng_start_sent`, and the start bit stays set until software writes it to 0.
- R7: In master mode (`eng_is_master`=1), `stop_req` is 1 while the stop bit and the enable are 1. The stop bit clears in the cycle after `eng_stop_done`.
- R8: In slave mode, a set stop bit gives one `slave_reset` cycle, never raises `stop_req`, and then clears.
- R9: A data-register write (`cpu_wr`=1, `cpu_sel_data`=1) sets the collision flag when the completion flag is 0 and clears it when the completion flag is 1.
- R10: `eng_enable` follows bit 2. While it is 0, `scl_hold`, `start_req`, `stop_req`, `ack_level`, `ack_pulse` and `slave_reset` are all 0.
- R11: `irq` is 1 exactly when bit 0, `glob_irq_en` and the completion flag are all 1.
- R12: After reset the control word reads 0x00 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_sel_data | input | 1 | 0 selects the control word, 1 selects the data register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Control word read-back |
| glob_irq_en | input | 1 | Global interrupt enable |
| eng_done | input | 1 | Engine finished an operation (pulse) |
| eng_start_sent | input | 1 | Engine has put a start condition on the bus (pulse) |
| eng_stop_done | input | 1 | Engine has executed a stop condition (pulse) |
| eng_bus_busy | input | 1 | Bus is currently owned by another transfer |
| eng_stop_seen | input | 1 | Stop condition detected on the bus (pulse) |
| eng_is_master | input | 1 | Engine is in master mode |
| eng_own_addr | input | 1 | Own slave address received |
| eng_gen_call | input | 1 | General-call address received |
| gcall_recog | input | 1 | General-call recognition enabled |
| eng_byte_rx | input | 1 | Data byte received in a receive mode |
| scl_hold | output | 1 | Request to stretch the clock low |
| start_req | output | 1 | Start condition request |
| stop_req | output | 1 | Stop condition request (master) |
| ack_level | output | 1 | Acknowledge enabled level |
| ack_pulse | output | 1 | Acknowledge this event |
| eng_go | output | 1 | Launch the next operation (one-cycle pulse) |
| slave_reset | output | 1 | Return to the unaddressed slave state (pulse) |
| eng_enable | output | 1 | Engine enable, which also hands the pins to the engine |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the engine behaves: it pulses `eng_done` only while enabled, `eng_start_sent` only while `start_req` is high, and `eng_stop_done` only while `stop_req` is high. The bench's random phase follows these rules. It chooses the mode first and derives each engine response from the reference model's current state, so every event it raises answers a request that is actually pending. Control writes come at random, and the enable bit is dropped now and then to exercise aborts.

// File: rtl/twc_ctrl_pkg.sv
package twc_ctrl_pkg;
  localparam int unsigned CTRL_W = 8;
  // bit positions of the control word (software decodes these)
  localparam int unsigned B_DONE = 7;
  localparam int unsigned B_ACK  = 6;
  localparam int unsigned B_STA  = 5;
  localparam int unsigned B_STO  = 4;
  localparam int unsigned B_WCOL = 3;
  localparam int unsigned B_EN   = 2;
  localparam int unsigned B_IE   = 0;

  typedef enum logic [1:0] {
    ARB_IDLE      = 2'd0,
    ARB_WAIT_STOP = 2'd1,
    ARB_REQ       = 2'd2,
    ARB_SENT      = 2'd3
  } arb_state_e;
endpackage

// File: rtl/twc_flag_unit.sv
module twc_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic done_evt,
  input  logic clr_wr,
  input  logic data_wr,
  output logic flag,
  output logic wcol,
  output logic go
);
  logic set_now, clr_now;

  assign set_now = done_evt & en;
  assign clr_now = clr_wr & flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      wcol <= 1'b0;
      go   <= 1'b0;
    end else begin
      if (set_now)      flag <= 1'b1;
      else if (clr_now) flag <= 1'b0;
      go <= clr_now & ~set_now;
      if (data_wr) wcol <= ~flag;
    end
  end
endmodule

// File: rtl/twc_start_arb.sv
module twc_start_arb import twc_ctrl_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic sta,
  input  logic en,
  input  logic bus_busy,
  input  logic stop_seen,
  input  logic start_sent,
  output logic start_req
);
  arb_state_e state, state_n;

  always_comb begin
    state_n = state;
    if (!(sta && en)) begin
      state_n = ARB_IDLE;
    end else begin
      unique case (state)
        ARB_IDLE:      state_n = bus_busy ? ARB_WAIT_STOP : ARB_REQ;
        ARB_WAIT_STOP: if (stop_seen) state_n = ARB_REQ;
        ARB_REQ:       if (start_sent) state_n = ARB_SENT;
        ARB_SENT:      state_n = ARB_SENT;
        default:       state_n = ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ARB_IDLE;
    else        state <= state_n;
  end

  assign start_req = (state == ARB_REQ) & sta & en;
endmodule

// File: rtl/twc_stop_unit.sv
module twc_stop_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic sto_wdata,
  input  logic en,
  input  logic is_master,
  input  logic stop_done,
  output logic sto,
  output logic stop_req,
  output logic slave_reset
);
  assign stop_req    = sto & en & is_master;
  assign slave_reset = sto & en & ~is_master;

  always_ff @(posedge clk) begin
    if (!rst_n)                                 sto <= 1'b0;
    else if (ctrl_wr)                           sto <= sto_wdata;
    else if (slave_reset || (stop_req && stop_done)) sto <= 1'b0;
  end
endmodule

// File: rtl/twc_ctrl_reg.sv
module twc_ctrl_reg import twc_ctrl_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_sel_data,
  input  logic [CTRL_W-1:0] cpu_wdata,
  output logic [CTRL_W-1:0] cpu_rdata,
  input  logic              glob_irq_en,
  input  logic              eng_done,
  input  logic              eng_start_sent,
  input  logic              eng_stop_done,
  input  logic              eng_bus_busy,
  input  logic              eng_stop_seen,
  input  logic              eng_is_master,
  input  logic              eng_own_addr,
  input  logic              eng_gen_call,
  input  logic              gcall_recog,
  input  logic              eng_byte_rx,
  output logic              scl_hold,
  output logic              start_req,
  output logic              stop_req,
  output logic              ack_level,
  output logic              ack_pulse,
  output logic              eng_go,
  output logic              slave_reset,
  output logic              eng_enable,
  output logic              irq
);
  logic ctrl_wr, data_wr;
  logic ack_q, sta_q, en_q, ie_q;
  logic flag, wcol, sto;
  logic unused_wbits;

  assign ctrl_wr      = cpu_wr & ~cpu_sel_data;
  assign data_wr      = cpu_wr & cpu_sel_data;
  assign unused_wbits = ^{cpu_wdata[B_WCOL], cpu_wdata[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      sta_q <= 1'b0;
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
    end else if (ctrl_wr) begin
      ack_q <= cpu_wdata[B_ACK];
      sta_q <= cpu_wdata[B_STA];
      en_q  <= cpu_wdata[B_EN];
      ie_q  <= cpu_wdata[B_IE];
    end
  end

  twc_flag_unit u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .done_evt (eng_done),
    .clr_wr   (ctrl_wr & cpu_wdata[B_DONE]),
    .data_wr  (data_wr),
    .flag     (flag),
    .wcol     (wcol),
    .go       (eng_go)
  );

  twc_start_arb u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .sta        (sta_q),
    .en         (en_q),
    .bus_busy   (eng_bus_busy),
    .stop_seen  (eng_stop_seen),
    .start_sent (eng_start_sent),
    .start_req  (start_req)
  );

  twc_stop_unit u_stop (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .sto_wdata   (cpu_wdata[B_STO]),
    .en          (en_q),
    .is_master   (eng_is_master),
    .stop_done   (eng_stop_done),
    .sto         (sto),
    .stop_req    (stop_req),
    .slave_reset (slave_reset)
  );

  always_comb begin
    cpu_rdata         = '0;
    cpu_rdata[B_DONE] = flag;
    cpu_rdata[B_ACK]  = ack_q;
    cpu_rdata[B_STA]  = sta_q;
    cpu_rdata[B_STO]  = sto;
    cpu_rdata[B_WCOL] = wcol;
    cpu_rdata[B_EN]   = en_q;
    cpu_rdata[B_IE]   = ie_q;
  end

  assign eng_enable = en_q;
  assign scl_hold   = flag & en_q;
  assign ack_level  = ack_q & en_q;
  assign ack_pulse  = ack_level & (eng_own_addr | (eng_gen_call & gcall_recog) | eng_byte_rx);
  assign irq        = ie_q & glob_irq_en & flag;
endmodule

// File: rtl/twc_ctrl_reg_chk.sv
module twc_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic       cpu_sel_data,
  input logic [7:0] cpu_rdata,
  input logic       glob_irq_en,
  input logic       eng_done,
  input logic       eng_stop_done,
  input logic       scl_hold,
  input logic       start_req,
  input logic       stop_req,
  input logic       ack_level,
  input logic       eng_go,
  input logic       slave_reset,
  input logic       eng_enable,
  input logic       irq
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[1] == 1'b0);

  a_r3_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);

  a_r3_go_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> !cpu_rdata[7]);

  a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_enable) |=> cpu_rdata[7]);

  a_r6_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (eng_enable && cpu_rdata[5]));

  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && eng_stop_done && !(cpu_wr && !cpu_sel_data)) |=> !cpu_rdata[4]);

  a_r8_recover_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_reset && !(cpu_wr && !cpu_sel_data)) |=> (!slave_reset && !cpu_rdata[4]));

  a_r9_collision_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel_data && !cpu_rdata[7]) |=> cpu_rdata[3]);

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_enable |-> (!scl_hold && !start_req && !stop_req && !ack_level && !slave_reset));

  a_r11_irq_sources: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cpu_rdata[7] && cpu_rdata[0] && glob_irq_en));
endmodule

bind twc_ctrl_reg twc_ctrl_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_wr        (cpu_wr),
  .cpu_sel_data  (cpu_sel_data),
  .cpu_rdata     (cpu_rdata),
  .glob_irq_en   (glob_irq_en),
  .eng_done      (eng_done),
  .eng_stop_done (eng_stop_done),
  .scl_hold      (scl_hold),
  .start_req     (start_req),
  .stop_req      (stop_req),
  .ack_level     (ack_level),
  .eng_go        (eng_go),
  .slave_reset   (slave_reset),
  .eng_enable    (eng_enable),
  .irq           (irq)
);

// File: tb/tb_twc_ctrl_reg.sv
module tb_twc_ctrl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 0, cpu_sel_data = 0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic glob_irq_en = 0, eng_done = 0, eng_start_sent = 0, eng_stop_done = 0;
  logic eng_bus_busy = 0, eng_stop_seen = 0, eng_is_master = 0;
  logic eng_own_addr = 0, eng_gen_call = 0, gcall_recog = 0, eng_byte_rx = 0;
  logic scl_hold, start_req, stop_req, ack_level, ack_pulse, eng_go, slave_reset, eng_enable, irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  twc_ctrl_reg dut (.*);

  // behavioural reference model
  bit m_flag, m_ack, m_sta, m_sto, m_wcol, m_en, m_ie, m_go;
  int m_arb; // 0 idle, 1 waiting for stop, 2 requesting, 3 start sent

  always @(posedge clk) begin
    bit wc, wd, setf, clrf, srst, sreq;
    int narb;
    if (!rst_n) begin
      m_flag = 0; m_ack = 0; m_sta = 0; m_sto = 0; m_wcol = 0;
      m_en = 0; m_ie = 0; m_go = 0; m_arb = 0;
    end else begin
      wc   = cpu_wr && !cpu_sel_data;
      wd   = cpu_wr && cpu_sel_data;
      setf = eng_done && m_en;
      clrf = wc && cpu_wdata[7] && m_flag;
      srst = m_sto && m_en && !eng_is_master;
      sreq = m_sto && m_en && eng_is_master;
      narb = m_arb;
      if (!(m_sta && m_en)) narb = 0;
      else if (m_arb == 0) narb = eng_bus_busy ? 1 : 2;
      else if (m_arb == 1 && eng_stop_seen) narb = 2;
      else if (m_arb == 2 && eng_start_sent) narb = 3;
      if (wd) m_wcol = !m_flag;
      m_go = clrf && !setf;
      if (setf) m_flag = 1; else if (clrf) m_flag = 0;
      if (wc) m_sto = cpu_wdata[4]; else if (srst || (sreq && eng_stop_done)) m_sto = 0;
      if (wc) begin
        m_ack = cpu_wdata[6]; m_sta = cpu_wdata[5]; m_en = cpu_wdata[2]; m_ie = cpu_wdata[0];
      end
      m_arb = narb;
    end
  end

  function automatic bit exp_start();
    return (m_arb == 2) && m_sta && m_en;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] er;
    bit eack;
    er = {m_flag, m_ack, m_sta, m_sto, m_wcol, m_en, 1'b0, m_ie};
    eack = m_ack && m_en && (eng_own_addr || (eng_gen_call && gcall_recog) || eng_byte_rx);
    chk(cpu_rdata === er, "R1 rdata", cpu_rdata, er);
    chk(scl_hold === (m_flag && m_en), "R2 scl_hold", scl_hold, m_flag && m_en);
    chk(eng_go === m_go, "R3 eng_go", eng_go, m_go);
    chk(ack_level === (m_ack && m_en), "R5 ack_level", ack_level, m_ack && m_en);
    chk(ack_pulse === eack, "R5 ack_pulse", ack_pulse, eack);
    chk(start_req === exp_start(), "R6 start_req", start_req, exp_start());
    chk(stop_req === (m_sto && m_en && eng_is_master), "R7 stop_req", stop_req, m_sto && m_en && eng_is_master);
    chk(slave_reset === (m_sto && m_en && !eng_is_master), "R8 slave_reset", slave_reset, m_sto && m_en && !eng_is_master);
    chk(eng_enable === m_en, "R10 eng_enable", eng_enable, m_en);
    chk(irq === (m_ie && glob_irq_en && m_flag), "R11 irq", irq, m_ie && glob_irq_en && m_flag);
  endtask

  // one clock: inputs already applied; compare after the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic clear_pulses();
    cpu_wr = 0; eng_done = 0; eng_start_sent = 0; eng_stop_done = 0; eng_stop_seen = 0;
    eng_own_addr = 0; eng_gen_call = 0; eng_byte_rx = 0;
  endtask

  task automatic ctrl_wr(input logic [7:0] v);
    cpu_wr = 1; cpu_sel_data = 0; cpu_wdata = v;
    tick();
    clear_pulses();
  endtask

  task automatic data_wr();
    cpu_wr = 1; cpu_sel_data = 1; cpu_wdata = 8'hA5;
    tick();
    clear_pulses();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    // R12: reset state
    chk(cpu_rdata === 8'h00, "R12 reset word", cpu_rdata, 8'h00);
    chk({scl_hold, start_req, stop_req, ack_level, eng_go, slave_reset, eng_enable, irq} === 8'h00,
        "R12 reset outputs", {scl_hold, start_req, stop_req, ack_level, eng_go, slave_reset, eng_enable, irq}, 8'h00);

    // R1: bits 3 and 1 ignore control writes
    ctrl_wr(8'h0F);
    chk(cpu_rdata === 8'h05, "R1 write mask", cpu_rdata, 8'h05);
    glob_irq_en = 1;

    // R4 and R11: done sets flag, raises irq and stretch
    eng_done = 1; tick(); clear_pulses();
    chk(cpu_rdata[7] === 1'b1, "R4 done sets flag", cpu_rdata, 8'h85);
    chk(irq === 1'b1, "R11 irq raised", irq, 1);
    chk(scl_hold === 1'b1, "R2 stretch while flag", scl_hold, 1);

    // R3: writing 0 to bit 7 does nothing; writing 1 clears and launches
    ctrl_wr(8'h05);
    chk(cpu_rdata[7] === 1'b1, "R3 zero write keeps flag", cpu_rdata, 8'h85);
    idle(2);
    chk(cpu_rdata[7] === 1'b1, "R3 no self clear", cpu_rdata, 8'h85);
    ctrl_wr(8'h85);
    chk(eng_go === 1'b1 && cpu_rdata[7] === 1'b0, "R3 go with clear", {eng_go, cpu_rdata[6:0]}, 8'h85);
    tick();
    chk(eng_go === 1'b0, "R3 go one cycle", eng_go, 0);

    // R4: set wins over simultaneous clear
    eng_done = 1; tick(); clear_pulses();
    eng_done = 1; ctrl_wr(8'h85);
    chk(cpu_rdata[7] === 1'b1 && eng_go === 1'b0, "R4 set wins", {eng_go, cpu_rdata[7]}, 8'h01);

    // R9: collision flag
    data_wr();
    chk(cpu_rdata[3] === 1'b0, "R9 write with flag set", cpu_rdata, 8'h85);
    ctrl_wr(8'h85);
    data_wr();
    chk(cpu_rdata[3] === 1'b1, "R9 write with flag clear", cpu_rdata, 8'h0D);

    // R5: acknowledge conditions
    ctrl_wr(8'h45);
    eng_gen_call = 1; tick();
    chk(ack_pulse === 1'b0, "R5 general call not recognised", ack_pulse, 0);
    gcall_recog = 1; tick();
    chk(ack_pulse === 1'b1, "R5 general call recognised", ack_pulse, 1);
    clear_pulses(); eng_own_addr = 1; tick();
    chk(ack_pulse === 1'b1, "R5 own address", ack_pulse, 1);
    clear_pulses();
    ctrl_wr(8'h05); eng_byte_rx = 1; tick();
    chk(ack_pulse === 1'b0, "R5 ack disabled", ack_pulse, 0);
    clear_pulses();

    // R6: start with free bus
    ctrl_wr(8'h25);
    chk(start_req === 1'b0, "R6 start latency", start_req, 0);
    tick();
    chk(start_req === 1'b1, "R6 start free bus", start_req, 1);
    eng_start_sent = 1; tick(); clear_pulses();
    chk(start_req === 1'b0 && cpu_rdata[5] === 1'b1, "R6 start sent, bit held", {start_req, cpu_rdata[5]}, 8'h01);
    ctrl_wr(8'h05);

    // R6: start with busy bus waits for a stop
    eng_bus_busy = 1;
    ctrl_wr(8'h25);
    idle(3);
    chk(start_req === 1'b0, "R6 waiting on busy bus", start_req, 0);
    eng_stop_seen = 1; eng_bus_busy = 0; tick(); clear_pulses();
    tick();
    chk(start_req === 1'b1, "R6 start after stop seen", start_req, 1);
    ctrl_wr(8'h05);

    // R7: master stop
    eng_is_master = 1;
    ctrl_wr(8'h15);
    chk(stop_req === 1'b1, "R7 stop request", stop_req, 1);
    idle(2);
    eng_stop_done = 1; tick(); clear_pulses();
    chk(cpu_rdata[4] === 1'b0 && stop_req === 1'b0, "R7 stop bit cleared", cpu_rdata, 8'h05);

    // R8: slave stop recovery
    eng_is_master = 0;
    ctrl_wr(8'h15);
    chk(slave_reset === 1'b1 && stop_req === 1'b0, "R8 recovery pulse", {slave_reset, stop_req}, 8'h02);
    tick();
    chk(slave_reset === 1'b0 && cpu_rdata[4] === 1'b0, "R8 recovery ends", {slave_reset, cpu_rdata[4]}, 8'h00);

    // R10: disable aborts
    eng_done = 1; tick(); clear_pulses();
    ctrl_wr(8'h65);
    tick();
    ctrl_wr(8'h60);
    chk({eng_enable, scl_hold, start_req, ack_level} === 4'b0000, "R10 disable quiets outputs",
        {eng_enable, scl_hold, start_req, ack_level}, 8'h00);

    // random phase, engine responses follow the pending requests
    for (int n = 0; n < 4000; n++) begin
      eng_is_master = ($urandom % 2) == 1;
      eng_bus_busy  = ($urandom % 3) == 0;
      glob_irq_en   = ($urandom % 4) != 0;
      gcall_recog   = ($urandom % 2) == 1;
      eng_own_addr  = ($urandom % 5) == 0;
      eng_gen_call  = ($urandom % 5) == 0;
      eng_byte_rx   = ($urandom % 5) == 0;
      eng_stop_seen = ($urandom % 4) == 0;
      eng_done      = m_en && (($urandom % 6) == 0);
      eng_start_sent = exp_start() && (($urandom % 2) == 1);
      eng_stop_done = m_sto && m_en && eng_is_master && (($urandom % 2) == 1);
      cpu_wr        = ($urandom % 5) == 0;
      cpu_sel_data  = ($urandom % 3) == 0;
      cpu_wdata     = 8'($urandom);
      cpu_wdata[2]  = ($urandom % 8) != 0;
      tick();
    end
    clear_pulses();
    tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule